// File: doc/BRIEF.md
# DMA Request Source Router

This block sits in front of a four-channel DMA scheduler. It decides which of 64 peripheral request lines drives each channel. Every channel has its own configuration: an enable bit, a pacing bit and a 6-bit source number. The result is one request line per channel, sent on to the scheduler. Peripheral request inputs are asynchronous, so they pass through a two-flop synchronizer before any channel picks one.

Two source numbers have a fixed meaning. Source 0 is the "nothing selected" code. Sources 60 through 63 are tied high inside the block, for channels that should request without stopping. Channels 0 and 1 can also be paced by periodic timers 0 and 1, which arrive as single-cycle pulses. In paced mode, each timer pulse that meets a high source level arms one single-transfer request. That request is held until the DMA acknowledges it.

Software is expected to clear enable and pacing before changing the source, and then set them again. While enable is low, the channel is silent and its armed request is dropped.

Top module: `dma_req_router`

## Requirements
- R1: When a channel's enable bit is 0, its `ch_req` is 0 in the same cycle, for every source and pacing setting. Any armed paced request is discarded, so setting enable again does not bring it back.
- R2: With source number 0, the channel never requests, whatever the 64 request inputs are.
- R3: With a source number from 60 to 63 and pacing off, the enabled channel requests continuously, whatever the request inputs are.
- R4: With a source number s from 1 to 59 and pacing off, `ch_req` equals `periph_req[s]` as it was two rising clock edges earlier (two-flop synchronizer).
- R5: On channel 0 or 1 with pacing set, the channel arms on a rising edge where its timer pulse is 1 and the synchronized source level is 1. A pulse that meets a low level is ignored, and no request appears without a pulse.
- R6: An armed paced request stays high until a rising edge where that channel's `dma_ack` bit is 1, which clears it. If a pulse that would arm the channel arrives on the same edge as the ack, the channel stays armed.
- R7: The pacing bit has no effect on channels 2 and 3, which always follow the selected source level.
- R8: Timer k paces only channel k (k = 0, 1). A pulse on one timer leaves the other channel unchanged.
- R9: Reset clears the synchronizer and all armed paced requests. The source field of channel c is `cfg_src[6*c+5 : 6*c]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| periph_req | input | 64 | Asynchronous peripheral request levels, bit s = source s |
| cfg_enable | input | 4 | Per-channel enable |
| cfg_pace | input | 4 | Per-channel timer pacing (used on channels 0 and 1 only) |
| cfg_src | input | 24 | Per-channel 6-bit source number, channel c at bits 6c+5..6c |
| tmr_pulse | input | 2 | Synchronous single-cycle timer pulses, bit k paces channel k |
| dma_ack | input | 4 | Per-channel acknowledge from the DMA, clears an armed paced request |
| ch_req | output | 4 | Per-channel request toward the scheduler |

## Verification
The assertions assume that `tmr_pulse`, `dma_ack` and the configuration inputs are synchronous to `clk`. They also assume that `periph_req` is quiet during reset, because the latency check compares against request values from before the synchronizer was filled. The stimulus drives every input on the falling edge and holds `periph_req` at zero across each reset. It changes a channel's source only while that channel is disabled or in a level mode, never while a paced request is armed.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
  localparam int unsigned DEF_NUM_CH      = 4;
  localparam int unsigned DEF_NUM_SRC     = 64;
  localparam int unsigned DEF_ALWAYS_BASE = 60;
  localparam int unsigned DEF_NUM_PACED   = 2;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_LEVEL = 2'd1,
    MODE_PACED = 2'd2
  } chan_mode_e;
endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_in;
      stab_q <= meta_q;
    end
  end

  assign sync_out = stab_q;

  // warm-up counter so the latency check never looks before reset
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_q <= '0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  // R4
  sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2) |-> (sync_out == $past(async_in, 2)));
endmodule

// File: rtl/dma_req_chan.sv
module dma_req_chan
  import dma_req_pkg::*;
#(
  parameter int unsigned NUM_SRC      = DEF_NUM_SRC,
  parameter int unsigned ALWAYS_BASE  = DEF_ALWAYS_BASE,
  parameter bit          PACE_CAPABLE = 1'b1,
  localparam int unsigned SEL_W       = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_sync,
  input  logic               en,
  input  logic               pace,
  input  logic [SEL_W-1:0]   sel,
  input  logic               pulse,
  input  logic               ack,
  output logic               req
);
  // level seen by this channel for a given source number
  function automatic logic src_level(input logic [NUM_SRC-1:0] v,
                                     input logic [SEL_W-1:0]   s);
    if (s == '0)                    return 1'b0;
    if (int'(s) >= ALWAYS_BASE)     return 1'b1;
    return v[s];
  endfunction

  function automatic chan_mode_e pick_mode(input logic e, input logic p);
    if (!e)                 return MODE_OFF;
    if (PACE_CAPABLE && p)  return MODE_PACED;
    return MODE_LEVEL;
  endfunction

  chan_mode_e mode;
  logic       lvl;
  logic       pace_fire;
  logic       pend_q;

  assign mode      = pick_mode(en, pace);
  assign lvl       = src_level(src_sync, sel);
  assign pace_fire = (mode == MODE_PACED) && pulse && lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  pend_q <= 1'b0;
    else if (mode != MODE_PACED) pend_q <= 1'b0;
    else                         pend_q <= (pend_q && !ack) || pace_fire;
  end

  always_comb begin
    unique case (mode)
      MODE_LEVEL: req = lvl;
      MODE_PACED: req = pend_q;
      default:    req = 1'b0;
    endcase
  end

  // R1
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !req);
  // R2
  sel_zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == '0) |-> !req);
  // R3
  always_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_LEVEL && int'(sel) >= ALWAYS_BASE) |-> req);
  // R5
  pace_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(pace_fire));
  // R6
  pace_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !ack && mode == MODE_PACED) |=> pend_q);
  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && ack && !pace_fire) |=> !pend_q);
endmodule

// File: rtl/dma_req_router.sv
module dma_req_router
  import dma_req_pkg::*;
#(
  parameter int unsigned NUM_CH      = DEF_NUM_CH,
  parameter int unsigned NUM_SRC     = DEF_NUM_SRC,
  parameter int unsigned ALWAYS_BASE = DEF_ALWAYS_BASE,
  parameter int unsigned NUM_PACED   = DEF_NUM_PACED,
  localparam int unsigned SEL_W      = $clog2(NUM_SRC)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_SRC-1:0]      periph_req,
  input  logic [NUM_CH-1:0]       cfg_enable,
  input  logic [NUM_CH-1:0]       cfg_pace,
  input  logic [NUM_CH*SEL_W-1:0] cfg_src,
  input  logic [NUM_PACED-1:0]    tmr_pulse,
  input  logic [NUM_CH-1:0]       dma_ack,
  output logic [NUM_CH-1:0]       ch_req
);
  logic [NUM_SRC-1:0] src_sync;

  dma_req_sync #(.W(NUM_SRC)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (periph_req),
    .sync_out (src_sync)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic ch_pulse;
    if (c < NUM_PACED) begin : g_paced
      assign ch_pulse = tmr_pulse[c];
    end else begin : g_plain
      assign ch_pulse = 1'b0;
    end

    dma_req_chan #(
      .NUM_SRC      (NUM_SRC),
      .ALWAYS_BASE  (ALWAYS_BASE),
      .PACE_CAPABLE (c < NUM_PACED)
    ) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_sync (src_sync),
      .en       (cfg_enable[c]),
      .pace     (cfg_pace[c]),
      .sel      (cfg_src[c*SEL_W +: SEL_W]),
      .pulse    (ch_pulse),
      .ack      (dma_ack[c]),
      .req      (ch_req[c])
    );
  end
endmodule

// File: tb/dma_req_router_bench.sv
`timescale 1ns/1ps
module dma_req_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] periph_req = '0;
  logic [3:0]  cfg_enable = '0;
  logic [3:0]  cfg_pace = '0;
  logic [23:0] cfg_src = '0;
  logic [1:0]  tmr_pulse = '0;
  logic [3:0]  dma_ack = '0;
  logic [3:0]  ch_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dma_req_router u_dma_req_router (
    .clk(clk), .rst_n(rst_n), .periph_req(periph_req),
    .cfg_enable(cfg_enable), .cfg_pace(cfg_pace), .cfg_src(cfg_src),
    .tmr_pulse(tmr_pulse), .dma_ack(dma_ack), .ch_req(ch_req)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    #0.5;
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // expected channel level for a source number, built from the requirements
  function automatic logic model_level(input logic [63:0] v, input int s);
    case (1'b1)
      (s >= 60): return 1'b1;
      (s <= 0):  return 1'b0;
      default:   return v[s];
    endcase
  endfunction

  task automatic set_src(input int c, input int s);
    cfg_src[c*6 +: 6] = 6'(s);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    tick(3);
    // R9 quiet under reset
    check("R9 reset", ch_req[0], 1'b0);
    rst_n = 1'b1;
    tick(2);

    // R2 R3 R4 exhaustive source sweep on every channel, pacing off
    for (int c = 0; c < 4; c++) begin
      cfg_enable = 4'b0;
      cfg_pace = '0;
      set_src(c, 0);
      cfg_enable[c] = 1'b1;
      for (int s = 0; s < 64; s++) begin
        set_src(c, s);
        for (int pat = 0; pat < 2; pat++) begin
          periph_req = (pat == 0) ? (64'd1 << s) : ~(64'd1 << s);
          tick(2);
          check(s == 0 ? "R2 src0" : (s >= 60 ? "R3 always" : "R4 follow"),
                ch_req[c], model_level(periph_req, s));
        end
      end
    end

    // R4 exact two-edge latency on channel 3, source 17
    cfg_enable = 4'b1000; set_src(3, 17); periph_req = '0; tick(3);
    periph_req[17] = 1'b1;
    tick(1); check("R4 latency one edge", ch_req[3], 1'b0);
    tick(1); check("R4 latency two edges", ch_req[3], 1'b1);

    // R1 enable low forces zero for all sources
    periph_req = '1;
    for (int s = 0; s < 64; s += 7) begin
      cfg_enable = 4'b0; set_src(1, s); cfg_pace = 4'b0010;
      tick(3); check("R1 disabled", ch_req[1], 1'b0);
    end

    // R5 paced channel 0 on always-on source
    cfg_pace = 4'b0011; set_src(0, 60); set_src(1, 61);
    cfg_enable = 4'b0011; tick(3);
    check("R5 no pulse", ch_req[0], 1'b0);
    tmr_pulse = 2'b01; tick(1); tmr_pulse = '0;
    check("R5 armed", ch_req[0], 1'b1);
    // R8 timer 0 left channel 1 alone
    check("R8 ch1 untouched", ch_req[1], 1'b0);
    // R6 held
    tick(5); check("R6 hold", ch_req[0], 1'b1);
    dma_ack = 4'b0001; tick(1); dma_ack = '0;
    check("R6 ack clears", ch_req[0], 1'b0);
    // R6 pulse and ack on same edge keeps it armed
    tmr_pulse = 2'b01; tick(1);
    dma_ack = 4'b0001; tick(1); tmr_pulse = '0; dma_ack = '0;
    check("R6 pulse with ack", ch_req[0], 1'b1);
    dma_ack = 4'b0001; tick(1); dma_ack = '0;
    check("R6 ack clears again", ch_req[0], 1'b0);
    // R8 timer 1 paces channel 1 only
    tmr_pulse = 2'b10; tick(1); tmr_pulse = '0;
    check("R8 ch1 armed", ch_req[1], 1'b1);
    check("R8 ch0 untouched", ch_req[0], 1'b0);
    dma_ack = 4'b0010; tick(1); dma_ack = '0;
    check("R6 ch1 ack", ch_req[1], 1'b0);

    // R5 pulse meeting low source level is ignored
    cfg_enable = 4'b0; cfg_pace = 4'b0; set_src(0, 5);
    periph_req = '0; cfg_pace = 4'b0001; cfg_enable = 4'b0001; tick(3);
    tmr_pulse = 2'b01; tick(1); tmr_pulse = '0;
    check("R5 low level ignored", ch_req[0], 1'b0);
    periph_req[5] = 1'b1; tick(3);
    check("R5 level alone no req", ch_req[0], 1'b0);
    tmr_pulse = 2'b01; tick(1); tmr_pulse = '0;
    check("R5 pulse with level", ch_req[0], 1'b1);

    // R1 disabling drops the armed request for good
    cfg_enable = 4'b0; tick(1);
    check("R1 off drops", ch_req[0], 1'b0);
    cfg_enable = 4'b0001; tick(1);
    check("R1 re-enable stays clear", ch_req[0], 1'b0);

    // R7 pacing ignored on channels 2 and 3
    cfg_enable = 4'b0; cfg_pace = 4'b1100; set_src(2, 62); set_src(3, 9);
    periph_req = '0; cfg_enable = 4'b1100; tick(3);
    check("R7 ch2 level", ch_req[2], 1'b1);
    check("R7 ch3 low", ch_req[3], 1'b0);
    periph_req[9] = 1'b1; tick(2);
    check("R7 ch3 follows", ch_req[3], 1'b1);
    periph_req[9] = 1'b0; tick(2);
    check("R7 ch3 drops", ch_req[3], 1'b0);

    // R9 reset clears an armed request
    cfg_enable = 4'b0; cfg_pace = 4'b0001; set_src(0, 63); cfg_enable = 4'b0001;
    tick(1); tmr_pulse = 2'b01; tick(1); tmr_pulse = '0;
    check("R9 armed before reset", ch_req[0], 1'b1);
    periph_req = '0; rst_n = 1'b0; tick(2);
    check("R9 cleared in reset", ch_req[0], 1'b0);
    rst_n = 1'b1; tick(2);
    check("R9 cleared after reset", ch_req[0], 1'b0);

    done = 1'b1;
    summary();
  end
endmodule